// File: doc/BRIEF.md
# Inter-Processor Event Flag Channel

The block links two processors, called side A and side B, through two mirrored banks of one-bit event flags. Each bank carries events in one direction, from A to B or from B to A. Each has 32 independent channels. A sender raises channel n by writing a 1 to bit n of its set register. The receiver sees the flag in its status view and clears it by writing a 1 to bit n of its acknowledge register. The sender watches the same flag in its own flag view, and while the flag is high it knows the receiver still owns any shared buffer tied to that channel.

Each processor reaches the block through its own single-cycle register port. The port has a write strobe, a word address and write data, and read data that follows the address combinationally. The lowest four channels of each direction also drive level interrupts toward the receiving processor, so the receiver does not have to poll for those events. Flags reset to 0. The block does not refuse a set onto a flag that is already raised. Testing the flag before setting it is left to the sender's software.

Top module: `ipc_event_mailbox`

## Requirements
- R1: A write to word offset 0 (outgoing set) raises outgoing flag n on the next clock edge for every bit n that is 1 in the write data.
- R2: Each port reads its outgoing flags at word offset 1 and its incoming flags at word offset 2. The sender's offset-1 view and the receiver's offset-2 view of one direction always hold the same value.
- R3: A write to word offset 3 (incoming acknowledge) clears incoming flag n on the next clock edge for every bit n that is 1 in the write data.
- R4: When a set and an acknowledge reach the same channel in the same cycle, the flag is 1 afterwards.
- R5: A set onto a flag that is already 1 leaves it at 1 and does not change any other flag.
- R6: Interrupt bit k (k = 0..3) of a port equals incoming flag k. It drops on the clock edge that takes an acknowledge of that channel.
- R7: Reads of offset 0, offset 3 and any word offset from 4 to 15 return 0.
- R8: Zero bits in set or acknowledge data, writes to offsets 1, 2 or 4 to 15, and cycles with no write all leave every flag unchanged.
- R9: While reset is asserted, and after it is released, all flags, read views and interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_we | input | 1 | Side A write strobe |
| a_addr | input | 4 | Side A word address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data |
| a_irq | output | 4 | Interrupts to A from the B-to-A channels 0..3 |
| b_we | input | 1 | Side B write strobe |
| b_addr | input | 4 | Side B word address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data |
| b_irq | output | 4 | Interrupts to B from the A-to-B channels 0..3 |

## Verification
A sender's set and the receiver's acknowledge can land on the same direction's flags in the same cycle, because they arrive on different ports. The bench forces this directly with one overlapping channel. Random traffic then drives both ports writing to any offset, and over many cycles set and acknowledge often meet, on shared bits and on separate bits. Each outcome is judged against a bench model in which the set wins over the acknowledge, and it is read back through both views and the interrupt lines.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  typedef enum logic [1:0] {
    OFS_SET = 2'd0,
    OFS_FLG = 2'd1,
    OFS_STS = 2'd2,
    OFS_ACK = 2'd3
  } ofs_e;
endpackage

// File: rtl/ipc_rst_sync.sv
module ipc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ipc_flag_bank.sv
module ipc_flag_bank #(
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] ack_i,
  output logic [NUM_CH-1:0] flag_o
);
  logic [NUM_CH-1:0] flag_q, flag_d;
  logic              upd_en;

  assign upd_en = (|set_i) | (|ack_i);

  always_comb begin
    flag_d = (flag_q & ~ack_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= '0;
    else if (upd_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  p_set_raises_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flag_q & $past(set_i)) == $past(set_i)));

  p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack_i & ~set_i)) |=> ((flag_q & $past(ack_i & ~set_i)) == '0));

  p_set_beats_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack_i & set_i)) |=> ((flag_q & $past(ack_i & set_i)) == $past(ack_i & set_i)));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0 && ack_i == '0) |=> $stable(flag_q));
endmodule

// File: rtl/ipc_reg_port.sv
module ipc_reg_port
  import ipc_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int ADDR_W = 4
) (
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NUM_CH-1:0] wdata,
  input  logic [NUM_CH-1:0] out_flags,
  input  logic [NUM_CH-1:0] in_flags,
  output logic [NUM_CH-1:0] set_o,
  output logic [NUM_CH-1:0] ack_o,
  output logic [NUM_CH-1:0] rdata
);
  logic hit;
  ofs_e sel;

  assign hit = (addr[ADDR_W-1:2] == '0);
  assign sel = ofs_e'(addr[1:0]);

  always_comb begin
    set_o = '0;
    ack_o = '0;
    if (we && hit) begin
      if (sel == OFS_SET) set_o = wdata;
      if (sel == OFS_ACK) ack_o = wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      case (sel)
        OFS_FLG: rdata = out_flags;
        OFS_STS: rdata = in_flags;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ipc_event_mailbox.sv
module ipc_event_mailbox #(
  parameter int NUM_CH  = 32,
  parameter int NUM_IRQ = 4,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               a_we,
  input  logic [ADDR_W-1:0]  a_addr,
  input  logic [NUM_CH-1:0]  a_wdata,
  output logic [NUM_CH-1:0]  a_rdata,
  output logic [NUM_IRQ-1:0] a_irq,
  input  logic               b_we,
  input  logic [ADDR_W-1:0]  b_addr,
  input  logic [NUM_CH-1:0]  b_wdata,
  output logic [NUM_CH-1:0]  b_rdata,
  output logic [NUM_IRQ-1:0] b_irq
);
  localparam int NUM_DIR = 2;
  localparam int DIR_AB  = 0;
  localparam int DIR_BA  = 1;

  logic              rst_n_sync;
  logic [NUM_CH-1:0] set_v  [NUM_DIR];
  logic [NUM_CH-1:0] ack_v  [NUM_DIR];
  logic [NUM_CH-1:0] flag_v [NUM_DIR];

  ipc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync));

  ipc_reg_port #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_port_a (
    .we(a_we), .addr(a_addr), .wdata(a_wdata),
    .out_flags(flag_v[DIR_AB]), .in_flags(flag_v[DIR_BA]),
    .set_o(set_v[DIR_AB]), .ack_o(ack_v[DIR_BA]), .rdata(a_rdata));

  ipc_reg_port #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_port_b (
    .we(b_we), .addr(b_addr), .wdata(b_wdata),
    .out_flags(flag_v[DIR_BA]), .in_flags(flag_v[DIR_AB]),
    .set_o(set_v[DIR_BA]), .ack_o(ack_v[DIR_AB]), .rdata(b_rdata));

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    ipc_flag_bank #(.NUM_CH(NUM_CH)) u_bank (
      .clk(clk), .rst_n(rst_n_sync),
      .set_i(set_v[d]), .ack_i(ack_v[d]), .flag_o(flag_v[d]));
  end

  assign b_irq = flag_v[DIR_AB][NUM_IRQ-1:0];
  assign a_irq = flag_v[DIR_BA][NUM_IRQ-1:0];

  p_views_agree_r2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (a_addr == ADDR_W'(1) && b_addr == ADDR_W'(2)) |-> (a_rdata == b_rdata));

  p_irq_drops_r6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (b_we && b_addr == ADDR_W'(3) && b_wdata[0] &&
     !(a_we && a_addr == ADDR_W'(0) && a_wdata[0])) |=> !b_irq[0]);

  p_blind_offsets_r7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (a_addr == ADDR_W'(0) || a_addr == ADDR_W'(3) || a_addr >= ADDR_W'(4)) |-> (a_rdata == '0));

  p_reset_quiet_r9: assert property (@(posedge clk)
    !rst_n_sync |-> (a_irq == '0 && b_irq == '0));
endmodule

// File: tb/tb_ipc_event_mailbox.sv
module tb_ipc_event_mailbox;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        a_we, b_we;
  logic [3:0]  a_addr, b_addr;
  logic [31:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic [3:0]  a_irq, b_irq;

  logic [31:0] m_ab, m_ba;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  ipc_event_mailbox dut (
    .clk(clk), .rst_n(rst_n),
    .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq(a_irq),
    .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq(b_irq));

  function automatic logic [31:0] next_flags(logic [31:0] f, logic [31:0] s, logic [31:0] k);
    return (f & ~k) | s;
  endfunction

  function automatic logic [31:0] wr_hit(logic we, logic [3:0] ad, logic [3:0] ofs, logic [31:0] d);
    return (we && ad == ofs) ? d : 32'h0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic awe, logic [3:0] aad, logic [31:0] awd,
                       logic bwe, logic [3:0] bad, logic [31:0] bwd);
    @(negedge clk);
    a_we = awe; a_addr = aad; a_wdata = awd;
    b_we = bwe; b_addr = bad; b_wdata = bwd;
    @(posedge clk);
    m_ab = next_flags(m_ab, wr_hit(awe, aad, 4'd0, awd), wr_hit(bwe, bad, 4'd3, bwd));
    m_ba = next_flags(m_ba, wr_hit(bwe, bad, 4'd0, bwd), wr_hit(awe, aad, 4'd3, awd));
  endtask

  task automatic read_all(string req);
    @(negedge clk);
    a_we = 1'b0; b_we = 1'b0;
    a_addr = 4'd1; b_addr = 4'd2; #1;
    check({req, " A FLG (R2)"}, a_rdata, m_ab);
    check({req, " B STS (R2)"}, b_rdata, m_ab);
    check({req, " B irq (R6)"}, {28'h0, b_irq}, {28'h0, m_ab[3:0]});
    @(negedge clk);
    a_addr = 4'd2; b_addr = 4'd1; #1;
    check({req, " A STS (R2)"}, a_rdata, m_ba);
    check({req, " B FLG (R2)"}, b_rdata, m_ba);
    check({req, " A irq (R6)"}, {28'h0, a_irq}, {28'h0, m_ba[3:0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_ab = '0; m_ba = '0;
    a_we = 0; b_we = 0; a_addr = 0; b_addr = 0; a_wdata = 0; b_wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); a_addr = 4'd1; b_addr = 4'd1; #1;
    check("R9 reset A FLG", a_rdata, 32'h0);
    check("R9 reset B FLG", b_rdata, 32'h0);
    check("R9 reset irqs", {24'h0, a_irq, b_irq}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    read_all("R9 after release");

    drive(1, 4'd0, 32'h0000_0020, 0, 0, 0);
    read_all("R1 set ch5");
    drive(1, 4'd0, 32'h0000_0020, 0, 0, 0);
    read_all("R5 reset of set ch5");
    drive(0, 0, 0, 1, 4'd1, 32'hFFFF_FFFF);
    drive(0, 0, 0, 1, 4'd2, 32'hFFFF_FFFF);
    drive(1, 4'd9, 32'hFFFF_FFFF, 1, 4'd12, 32'hFFFF_FFFF);
    read_all("R8 writes to views/unmapped");
    drive(0, 0, 0, 1, 4'd3, 32'h0);
    read_all("R8 zero ack");
    drive(0, 0, 0, 1, 4'd3, 32'h0000_0020);
    read_all("R3 ack ch5");
    drive(1, 4'd0, 32'h0000_0004, 1, 4'd3, 32'h0000_0004);
    read_all("R4 set+ack same cycle ch2");
    check("R4 ch2 stays set", m_ab & 32'h4, 32'h4);
    drive(1, 4'd0, 32'h0000_0002, 0, 0, 0);
    @(negedge clk); #1;
    check("R6 irq rises ch1", {28'h0, b_irq}, 32'h6);
    drive(0, 0, 0, 1, 4'd3, 32'h0000_0002);
    @(negedge clk); #1;
    check("R6 irq drops after ack ch1", {28'h0, b_irq}, 32'h4);
    drive(1, 4'd0, 32'hFFFF_FFFF, 0, 0, 0);
    read_all("R8 other direction untouched");
    drive(0, 0, 0, 1, 4'd0, 32'h8000_0009);
    read_all("R1 B sets");
    drive(1, 4'd3, 32'h0000_0001, 0, 0, 0);
    read_all("R3 A acks");

    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      a_we = 0; b_we = 0; a_addr = 4'(i); b_addr = 4'(i); #1;
      if (i == 0 || i == 3 || i >= 4) begin
        check("R7 blind read A", a_rdata, 32'h0);
        check("R7 blind read B", b_rdata, 32'h0);
      end
    end

    for (int i = 0; i < 400; i++) begin
      logic [31:0] da, db;
      logic [3:0]  aa, ab;
      da = $urandom; db = $urandom;
      case ($urandom % 3)
        0: da = 32'h1 << ($urandom % 32);
        1: da = da & $urandom & $urandom;
        default: ;
      endcase
      if ($urandom % 2 == 0) db = da;
      aa = ($urandom % 8 == 0) ? 4'($urandom) : 4'($urandom % 4);
      ab = ($urandom % 8 == 0) ? 4'($urandom) : 4'($urandom % 4);
      drive($urandom % 4 != 0, aa, da, $urandom % 4 != 0, ab, db);
      if (i % 4 == 3) read_all("R1/R3/R4/R8 random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule